// File: doc/BRIEF.md
# Parallel Capture Transfer Controller

This block moves words from an external parallel device into an on-chip FIFO, one direction only. It runs in one of three ways. In timed mode, a sample enable paces the capture, and triggers open and close a capture window. In burst mode, the external device holds a level request, and one word moves on every sample enable while request and acknowledge are both active. In strobe mode, each complete request/acknowledge exchange moves exactly one word.

All logic runs on one fast clock. The three internal sample rates are clock enables divided from that clock. The external sample clock is resynchronised and turned into an enable on its rising edge. The block offers the FIFO a registered write strobe with its data. It counts the words written. It keeps a sticky flag for words that were lost because the FIFO was full.

Top module: `pxfer_top`

## Requirements
- R1: After reset `fifoWr` is 0, `overflow` is 0 and `xferCount` is 0. `ack` is 0 in timed, burst and off modes, and 1 (inactive) in strobe mode.
- R2: `rateSel` picks the sample enable. Values 0, 1 and 2 give one enable every DIV_FAST (3), DIV_MID (4) and DIV_SLOW (6) clocks. During a timed run, one word is written per enable, and `xferCount` equals the number of words written since the run started.
- R3: With `rateSel` = 3, the enable comes from each rising edge of `extClk`, after a two-stage synchroniser. A timed run writes one word per external edge.
- R4: In timed mode (`mode` = 0), a trigger is held until the next enable. The enable that accepts a start writes nothing, and capture begins on the enable after it. The enable that accepts a stop writes nothing, and no later word is written.
- R5: A run starts on a `swStart` pulse, on a rising edge of `startPin`, or on a pattern match when `patStartEn` is set. A run stops on a `swStop` pulse, on a rising edge of `stopPin`, or on a pattern match when `patStopEn` is set. A pattern match means the masked data equals `patValue` on the bits set in `patMask`, within the selected width.
- R6: When `patStartEn` and `patStopEn` are both set, a match only starts a run and never stops it.
- R7: With `countEn` set, a timed run stops after exactly `countLimit` words.
- R8: `fifoData` holds the captured word masked to the width in `widthSel`. Value 0 keeps bits [7:0], value 1 keeps bits [15:0], and values 2 and 3 keep the full word. All other bits read as zero.
- R9: In burst mode (`mode` = 1), `req` and `ack` are active high. `ack` goes high the clock after `req` is high while the FIFO is not full. One word is written per enable while both are high, and none once `req` drops.
- R10: In strobe mode (`mode` = 2), `req` and `ack` are active low. A low `req` captures one word and drives `ack` low. `ack` stays low until `req` returns high, and a held request never yields a second word.
- R11: No word is written while `fifoFull` is high, and burst mode withholds `ack`. In a timed run, an enable that arrives while the FIFO is full drops its word and sets `overflow`.
- R12: `overflow` and `xferCount` clear on a `swStart` pulse or on an accepted timed start. Otherwise `overflow` stays set.
- R13: In off mode (`mode` = 3), no word is written and `ack` stays 0, whatever the triggers and `req` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 timed, 1 burst, 2 strobe, 3 off |
| rateSel | input | 2 | Sample enable source: 0/1/2 internal dividers, 3 external clock |
| extClk | input | 1 | External sample clock |
| widthSel | input | 2 | Word width: 0 byte, 1 half, 2/3 full |
| swStart | input | 1 | Software start pulse, also clears count and overflow |
| swStop | input | 1 | Software stop pulse |
| startPin | input | 1 | External start trigger, rising edge |
| stopPin | input | 1 | External stop trigger, rising edge |
| patStartEn | input | 1 | Pattern match starts a run |
| patStopEn | input | 1 | Pattern match stops a run |
| patMask | input | DATA_W | Bits compared by the pattern match |
| patValue | input | DATA_W | Pattern match value |
| countEn | input | 1 | Enable the finite word count stop |
| countLimit | input | CNT_W | Words per finite run |
| data | input | DATA_W | External data bus |
| req | input | 1 | Request from the external device |
| ack | output | 1 | Acknowledge to the external device |
| fifoFull | input | 1 | FIFO cannot take a word |
| fifoWr | output | 1 | FIFO write strobe |
| fifoData | output | DATA_W | FIFO write data |
| overflow | output | 1 | Sticky lost-word flag |
| xferCount | output | CNT_W | Words written |

## Verification
The bench holds a strobe request low for several clocks and expects exactly one word. A design that re-armed on a level request would fill the FIFO with copies. It confirms that the enable accepting a start or a stop writes nothing, and that a finite run ends at exactly the programmed count. Being off by one enable would show up as an extra or missing word. With both pattern enables set, it checks that a standing match keeps the run going; a design that let the stop match win would halt at once. It also checks that a full FIFO in timed mode drops words and latches `overflow`, where a wrong design would write anyway or lose the word silently. Finally, it checks that burst mode withholds `ack` while full.

// File: rtl/pxfer_pkg.sv
package pxfer_pkg;

  typedef enum logic [1:0] {
    MODE_TIMED  = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_STROBE = 2'd2,
    MODE_OFF    = 2'd3
  } xferMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take one word into the FIFO
    logic lost;     // a word arrived with no room
    logic clear;    // zero count and overflow
  } pathCmd_t;

endpackage

// File: rtl/pxfer_rate.sv
module pxfer_rate #(
  parameter int DIV_FAST = 3,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       extClk,
  output logic       tick
);

  localparam int N_INT = 3;

  logic [N_INT-1:0] intTick;
  logic [2:0]       extSh;
  logic             extTick;

  // one free-running divider per internal rate
  for (genvar g = 0; g < N_INT; g++) begin : gDiv
    localparam int D = (g == 0) ? DIV_FAST : ((g == 1) ? DIV_MID : DIV_SLOW);
    localparam int W = (D > 2) ? $clog2(D) : 1;
    logic [W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (cnt == W'(D - 1)) cnt <= '0;
      else cnt <= cnt + W'(1);
    end
    assign intTick[g] = (cnt == W'(D - 1));
  end

  // external clock: two-stage synchroniser plus edge stage
  always_ff @(posedge clk) begin
    if (!rstN) extSh <= '0;
    else extSh <= {extSh[1:0], extClk};
  end
  assign extTick = extSh[1] & ~extSh[2];

  always_comb begin
    case (rateSel)
      2'd0:    tick = intTick[0];
      2'd1:    tick = intTick[1];
      2'd2:    tick = intTick[2];
      default: tick = extTick;
    endcase
  end

endmodule

// File: rtl/pxfer_path.sv
module pxfer_path
  import pxfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCmd_t          cmd,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        widthSel,
  input  logic [DATA_W-1:0] patMask,
  input  logic [DATA_W-1:0] patValue,
  output logic              patHit,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              overflow,
  output logic [CNT_W-1:0]  xferCount
);

  localparam int BYTE_BITS = 8;
  localparam int HALF_BITS = 16;

  logic [DATA_W-1:0] laneMask;
  int                laneBits;

  always_comb begin
    case (widthSel)
      2'd0:    laneBits = BYTE_BITS;
      2'd1:    laneBits = HALF_BITS;
      default: laneBits = DATA_W;
    endcase
    for (int i = 0; i < DATA_W; i++) laneMask[i] = (i < laneBits);
  end

  assign patHit = (((data ^ patValue) & patMask & laneMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWr    <= 1'b0;
      fifoData  <= '0;
      overflow  <= 1'b0;
      xferCount <= '0;
    end else begin
      fifoWr <= cmd.capture;
      if (cmd.capture) fifoData <= data & laneMask;
      xferCount <= (cmd.clear ? '0 : xferCount) + CNT_W'(cmd.capture);
      overflow  <= (cmd.clear ? 1'b0 : overflow) | cmd.lost;
    end
  end

endmodule

// File: rtl/pxfer_ctrl.sv
module pxfer_ctrl
  import pxfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  xferMode_e        mode,
  input  logic             tick,
  input  logic             swStart,
  input  logic             swStop,
  input  logic             startPin,
  input  logic             stopPin,
  input  logic             patStartEn,
  input  logic             patStopEn,
  input  logic             patHit,
  input  logic             countEn,
  input  logic [CNT_W-1:0] countLimit,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             req,
  input  logic             fifoFull,
  output logic             ack,
  output pathCmd_t         cmd
);

  logic startPinQ, stopPinQ;
  logic startPend, stopPend;
  logic running;
  logic ackReg, holdSt;
  logic startReq, stopReq, patStartHit, patStopHit, limitHit;
  logic startAcc, stopAcc;

  assign startReq    = startPend | swStart | (startPin & ~startPinQ);
  assign stopReq     = stopPend  | swStop  | (stopPin  & ~stopPinQ);
  assign patStartHit = patStartEn & patHit;
  assign patStopHit  = patStopEn & ~patStartEn & patHit;
  assign limitHit    = countEn && (xferCount >= countLimit);

  always_comb begin
    cmd      = '0;
    startAcc = 1'b0;
    stopAcc  = 1'b0;
    case (mode)
      MODE_TIMED: begin
        if (tick) begin
          if (!running) startAcc = startReq | patStartHit;
          else if (stopReq | patStopHit | limitHit) stopAcc = 1'b1;
          else if (fifoFull) cmd.lost = 1'b1;
          else cmd.capture = 1'b1;
        end
      end
      MODE_BURST: begin
        if (tick && req && ackReg) begin
          if (fifoFull) cmd.lost = 1'b1;
          else cmd.capture = 1'b1;
        end
      end
      MODE_STROBE: begin
        // request is active low here
        if (!req && !holdSt && !fifoFull) cmd.capture = 1'b1;
      end
      default: ;
    endcase
    cmd.clear = swStart | startAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPinQ <= 1'b0;
      stopPinQ  <= 1'b0;
      startPend <= 1'b0;
      stopPend  <= 1'b0;
      running   <= 1'b0;
      ackReg    <= 1'b0;
      holdSt    <= 1'b0;
    end else begin
      startPinQ <= startPin;
      stopPinQ  <= stopPin;

      if (mode != MODE_TIMED) begin
        startPend <= 1'b0;
        stopPend  <= 1'b0;
        running   <= 1'b0;
      end else if (tick) begin
        startPend <= 1'b0;
        stopPend  <= 1'b0;
        if (startAcc) running <= 1'b1;
        else if (stopAcc) running <= 1'b0;
      end else begin
        if (startReq) startPend <= 1'b1;
        if (stopReq)  stopPend  <= 1'b1;
      end

      case (mode)
        MODE_BURST: begin
          ackReg <= req & ~fifoFull;
          holdSt <= 1'b0;
        end
        MODE_STROBE: begin
          if (cmd.capture) begin
            ackReg <= 1'b1;
            holdSt <= 1'b1;
          end else if (holdSt && req) begin
            ackReg <= 1'b0;
            holdSt <= 1'b0;
          end
        end
        default: begin
          ackReg <= 1'b0;
          holdSt <= 1'b0;
        end
      endcase
    end
  end

  assign ack = (mode == MODE_STROBE) ? ~ackReg : ackReg;

endmodule

// File: rtl/pxfer_top.sv
module pxfer_top
  import pxfer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int DIV_FAST = 3,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [1:0]        rateSel,
  input  logic              extClk,
  input  logic [1:0]        widthSel,
  input  logic              swStart,
  input  logic              swStop,
  input  logic              startPin,
  input  logic              stopPin,
  input  logic              patStartEn,
  input  logic              patStopEn,
  input  logic [DATA_W-1:0] patMask,
  input  logic [DATA_W-1:0] patValue,
  input  logic              countEn,
  input  logic [CNT_W-1:0]  countLimit,
  input  logic [DATA_W-1:0] data,
  input  logic              req,
  output logic              ack,
  input  logic              fifoFull,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              overflow,
  output logic [CNT_W-1:0]  xferCount
);

  logic     tick;
  logic     patHit;
  pathCmd_t cmd;

  pxfer_rate #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) uRate (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .extClk(extClk), .tick(tick)
  );

  pxfer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mode(xferMode_e'(mode)), .tick(tick),
    .swStart(swStart), .swStop(swStop), .startPin(startPin), .stopPin(stopPin),
    .patStartEn(patStartEn), .patStopEn(patStopEn), .patHit(patHit),
    .countEn(countEn), .countLimit(countLimit), .xferCount(xferCount),
    .req(req), .fifoFull(fifoFull), .ack(ack), .cmd(cmd)
  );

  pxfer_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .data(data), .widthSel(widthSel),
    .patMask(patMask), .patValue(patValue), .patHit(patHit),
    .fifoWr(fifoWr), .fifoData(fifoData), .overflow(overflow),
    .xferCount(xferCount)
  );

endmodule

// File: rtl/pxfer_chk.sv
module pxfer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             swStart,
  input logic             req,
  input logic             ack,
  input logic             fifoFull,
  input logic             fifoWr,
  input logic             overflow,
  input logic [CNT_W-1:0] xferCount
);

  AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> $past(!fifoFull)); // R11

  AST_BURST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && $past(mode) == 2'd1 && !$past(req)) |-> !ack); // R9

  AST_STROBE_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && $past(mode) == 2'd2 && $past(req)) |-> ack); // R10

  AST_STROBE_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWr && mode == 2'd2 && $past(mode) == 2'd2) |=> (mode != 2'd2 || !fifoWr)); // R10

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> (!fifoWr && !ack)); // R13

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> (xferCount == $past(xferCount) + CNT_W'(1) || xferCount == CNT_W'(1))); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> ($past(swStart) || $past(mode) == 2'd0)); // R12

endmodule

bind pxfer_top pxfer_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .mode(mode), .swStart(swStart), .req(req),
  .ack(ack), .fifoFull(fifoFull), .fifoWr(fifoWr), .overflow(overflow),
  .xferCount(xferCount)
);

// File: tb/sim_pxfer_top.sv
`timescale 1ns/1ps
module sim_pxfer_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0, rateSel = 2'd0, widthSel = 2'd2;
  logic        extClk = 1'b0, swStart = 1'b0, swStop = 1'b0;
  logic        startPin = 1'b0, stopPin = 1'b0;
  logic        patStartEn = 1'b0, patStopEn = 1'b0;
  logic [31:0] patMask = 32'h0, patValue = 32'h0;
  logic        countEn = 1'b0;
  logic [15:0] countLimit = 16'd0;
  logic [31:0] data = 32'h0;
  logic        req = 1'b0, fifoFull = 1'b0;
  logic        ack, fifoWr, overflow;
  logic [31:0] fifoData;
  logic [15:0] xferCount;

  int checks = 0, errors = 0;
  int wrCount = 0;
  logic [31:0] lastData = 32'h0;

  always #2.5 clk = ~clk;

  pxfer_top u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .rateSel(rateSel), .extClk(extClk),
    .widthSel(widthSel), .swStart(swStart), .swStop(swStop),
    .startPin(startPin), .stopPin(stopPin), .patStartEn(patStartEn),
    .patStopEn(patStopEn), .patMask(patMask), .patValue(patValue),
    .countEn(countEn), .countLimit(countLimit), .data(data), .req(req),
    .ack(ack), .fifoFull(fifoFull), .fifoWr(fifoWr), .fifoData(fifoData),
    .overflow(overflow), .xferCount(xferCount)
  );

  // word monitor
  always @(posedge clk) begin
    if (rstN && fifoWr) begin
      wrCount  = wrCount + 1;
      lastData = fifoData;
    end
  end

  // widthSel, data, expected fifoData
  localparam logic [65:0] VEC [0:3] = '{
    {2'd0, 32'hA5C3_7E19, 32'h0000_0019},
    {2'd1, 32'hA5C3_7E19, 32'h0000_7E19},
    {2'd2, 32'hA5C3_7E19, 32'hA5C3_7E19},
    {2'd3, 32'h0F0F_1234, 32'h0F0F_1234}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    swStart = 1'b1; cyc(1); swStart = 1'b0;
  endtask

  task automatic pulseStop();
    swStop = 1'b1; cyc(1); swStop = 1'b0;
  endtask

  task automatic extEdge();
    extClk = 1'b1; cyc(4); extClk = 1'b0; cyc(4);
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    int w0, w1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 fifoWr", fifoWr, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 xferCount", xferCount, 0);
    chk("R1 ack timed", ack, 0);

    // R8 / R10 strobe handshakes walked from the table
    mode = 2'd2; req = 1'b1; cyc(2);
    chk("R1 ack strobe idle", ack, 1);
    for (int i = 0; i < 4; i++) begin
      widthSel = VEC[i][65:64];
      data     = VEC[i][63:32];
      w0 = wrCount;
      req = 1'b0; cyc(4);
      chk("R10 ack asserted low", ack, 0);
      chk("R10 one word per handshake", wrCount - w0, 1);
      chk("R8 width mask", lastData, VEC[i][31:0]);
      req = 1'b1; cyc(2);
      chk("R10 ack released", ack, 1);
    end

    // R2/R4 timed mode, fast rate
    mode = 2'd0; widthSel = 2'd2; rateSel = 2'd0; data = 32'h1111_2222; cyc(2);
    w0 = wrCount;
    pulseStart(); cyc(2);
    chk("R4 start enable writes nothing", wrCount - w0, 0);
    cyc(57);
    pulseStop(); cyc(6);
    w1 = wrCount;
    chkRange("R2 words at div 3", w1 - w0, 18, 20);
    chk("R2 count matches words", xferCount, w1 - w0);
    cyc(15);
    chk("R4 no write after stop", wrCount - w1, 0);

    // R2 slow rate
    rateSel = 2'd2; cyc(2);
    w0 = wrCount;
    pulseStart(); cyc(59); pulseStop(); cyc(10);
    chkRange("R2 words at div 6", wrCount - w0, 8, 10);

    // R3 external clock
    rateSel = 2'd3; cyc(2);
    w0 = wrCount;
    pulseStart();
    for (int e = 0; e < 11; e++) extEdge();
    pulseStop();
    extEdge(); extEdge();
    chk("R3 one word per external edge", wrCount - w0, 10);

    // R5 pin triggers
    rateSel = 2'd0; cyc(2);
    w0 = wrCount;
    startPin = 1'b1; cyc(2); startPin = 1'b0; cyc(30);
    stopPin = 1'b1; cyc(2); stopPin = 1'b0; cyc(6);
    w1 = wrCount;
    chkRange("R5 pin started run", w1 - w0, 8, 11);
    cyc(15);
    chk("R5 pin stopped run", wrCount - w1, 0);

    // R5 pattern start
    patMask = 32'hFF; patValue = 32'h5A; patStartEn = 1'b1; data = 32'h0;
    w0 = wrCount; cyc(20);
    chk("R5 no match no start", wrCount - w0, 0);
    data = 32'h5A; cyc(3); data = 32'h33; cyc(20);
    stopPin = 1'b1; cyc(2); stopPin = 1'b0; cyc(6);
    chkRange("R5 pattern started run", wrCount - w0, 5, 8);
    chk("R5 last word after pattern start", lastData, 32'h33);

    // R6 both pattern enables: match keeps running
    patStopEn = 1'b1; data = 32'h5A; w0 = wrCount; cyc(30);
    chkRange("R6 match does not stop", wrCount - w0, 7, 10);
    pulseStop(); cyc(6);
    patStartEn = 1'b0;

    // R5 pattern stop
    data = 32'h11; pulseStart(); cyc(20);
    data = 32'h5A; cyc(8);
    w1 = wrCount; cyc(15);
    chk("R5 pattern stop halts", wrCount - w1, 0);
    chk("R5 no matching word written", lastData, 32'h11);
    patStopEn = 1'b0;

    // R7 finite count
    countEn = 1'b1; countLimit = 16'd5; w0 = wrCount;
    pulseStart(); cyc(60);
    chk("R7 count limit words", wrCount - w0, 5);
    chk("R7 count register", xferCount, 5);
    countEn = 1'b0;

    // R11/R12 timed overflow
    fifoFull = 1'b1; w0 = wrCount;
    pulseStart(); cyc(20);
    chk("R11 no write when full", wrCount - w0, 0);
    chk("R11 overflow set", overflow, 1);
    fifoFull = 1'b0; pulseStop(); cyc(6);
    chk("R12 overflow sticky", overflow, 1);
    pulseStart(); cyc(2);
    chk("R12 overflow cleared by start", overflow, 0);
    pulseStop(); cyc(6);

    // R9 burst
    mode = 2'd1; req = 1'b0; cyc(3);
    chk("R9 ack idle low", ack, 0);
    w0 = wrCount;
    req = 1'b1; cyc(2);
    chk("R9 ack follows req", ack, 1);
    cyc(58); req = 1'b0; cyc(3);
    w1 = wrCount;
    chkRange("R9 words while both high", w1 - w0, 18, 21);
    chk("R9 ack drops", ack, 0);
    cyc(10);
    chk("R9 no write after req drops", wrCount - w1, 0);

    // R11 burst withholds ack
    fifoFull = 1'b1; req = 1'b1; w0 = wrCount; cyc(10);
    chk("R11 burst ack withheld", ack, 0);
    chk("R11 burst no write", wrCount - w0, 0);
    req = 1'b0; fifoFull = 1'b0; cyc(3);

    // R13 off mode
    mode = 2'd3; req = 1'b1; w0 = wrCount;
    pulseStart(); cyc(20);
    chk("R13 off no write", wrCount - w0, 0);
    chk("R13 off ack", ack, 0);

    finish();
  end

endmodule